// File: doc/BRIEF.md
# GPIO Pad Controller with Banked Interrupts

A register-mapped controller for a parameterizable set of general-purpose pads. Each pad owns a 16-byte slot in the register space that holds two words: a configuration word (mux function, direct-interrupt flag, open-drain flag and three trigger-select bits) and a value word (active-low input enable, active-low output enable and the pin level). The controller drives each pad's output and output-enable from the value word. It synchronizes the pad inputs into the clock domain and detects edge or level events on them.

Detected events set bits in interrupt status words placed above the pad slots. Each status word covers 32 pins. Software clears status bits by writing ones. A single interrupt line is the OR of every status bit.

Software reaches the block through a flat 32-bit read/write port. Reads are combinational from the address and are presented while a read is strobed. Writes take effect on the clock edge.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0, every value word reads 0x6 (input and output disabled, level 0), every status word reads 0, `irq` is low and no `pad_oe` bit is set.
- R2: The configuration word of pad p is at byte address 16·p and the value word at 16·p+8. In the configuration word, bits 31 (open-drain), 27 (direct interrupt), 26:24 (trigger select) and 2:0 (mux) are stored and read back; all other bits read 0.
- R3: Value word bit 1 is an active-low output enable: with bit 1 = 0 and open-drain off, `pad_oe[p]` is 1 and `pad_out[p]` equals value bit 0; with bit 1 = 1, `pad_oe[p]` is 0.
- R4: With configuration bit 31 set, pad p drives only low: `pad_out[p]` is 0 and `pad_oe[p]` is 1 only when output is enabled and value bit 0 is 0.
- R5: Value word bit 2 is an active-low input enable. A read of the value word returns bits 2:1 as written; bit 0 returns the synchronized pad input when bit 2 = 0 and the stored level when bit 2 = 1.
- R6: Pad inputs pass through two flops; with bit 26 = negative, bit 25 = positive, bit 24 = level, positive alone captures rising edges, negative alone falling edges, both together either edge. The status bit is set at the third rising clock edge after the input changes.
- R7: With the level bit set, positive selects high-level and negative selects low-level triggering; the status bit is set again every clock while the level holds, so a clear has no lasting effect until the level goes inactive.
- R8: With all three trigger bits clear, or the level bit alone, the pin never sets its status bit.
- R9: Status word k is at byte address 0x800 + 4·k; bit j holds pin 32·k + j; bits for pins at or above the pad count read 0.
- R10: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R11: When a write-1 clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R12: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| pad_in | input | NUM_PADS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables, active high |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_PADS = 40. This gives one full status word and a second word in which only eight pins exist, so a bank-1 pin (35) can raise an interrupt and the unpopulated upper bits of word 1 can be shown to read zero. The last pad (39) sits at the top of the populated slot range, which checks the slot decode at its boundary. Edge latency is measured cycle by cycle on `irq`, and the same-cycle clear-versus-event race is staged by timing a status write against a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W     = 12;
  localparam int BANK_BITS  = 32;
  localparam int BIT_OD     = 31;
  localparam int BIT_DIRQ   = 27;
  localparam int BIT_NEG    = 26;
  localparam int BIT_POS    = 25;
  localparam int BIT_LVL    = 24;

  localparam logic [31:0] CFG_KEEP  = 32'h8F00_0007;
  localparam logic [2:0]  VAL_RESET = 3'b110;

  typedef enum logic [2:0] {
    TRIG_OFF, TRIG_RISE, TRIG_FALL, TRIG_EDGE, TRIG_HIGH, TRIG_LOW, TRIG_ANY
  } trig_mode_e;

  // trig = {neg, pos, lvl}
  function automatic trig_mode_e decode_trig(input logic [2:0] trig);
    logic neg, pos, lvl;
    neg = trig[2];
    pos = trig[1];
    lvl = trig[0];
    if (!lvl) begin
      if (pos && neg)  return TRIG_EDGE;
      else if (pos)    return TRIG_RISE;
      else if (neg)    return TRIG_FALL;
      else             return TRIG_OFF;
    end else begin
      if (pos && neg)  return TRIG_ANY;
      else if (pos)    return TRIG_HIGH;
      else if (neg)    return TRIG_LOW;
      else             return TRIG_OFF;
    end
  endfunction

  function automatic logic trig_hit(input trig_mode_e m, input logic cur,
                                    input logic prev);
    case (m)
      TRIG_RISE: return cur && !prev;
      TRIG_FALL: return !cur && prev;
      TRIG_EDGE: return cur != prev;
      TRIG_HIGH: return cur;
      TRIG_LOW:  return !cur;
      TRIG_ANY:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] cfg_store(input logic [31:0] w);
    return w & CFG_KEEP;
  endfunction

  // Value word as read: bit 0 follows the pad when input is enabled.
  function automatic logic [31:0] val_view(input logic [2:0] v, input logic pin);
    return {29'd0, v[2:1], (v[2] ? v[0] : pin)};
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // R6: the synchronized value is the input from two edges earlier
  p_two_flop_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH-1:0][2:0] trig_i,
  input  logic [WIDTH-1:0]      cur_i,
  input  logic [WIDTH-1:0]      prev_i,
  output logic [WIDTH-1:0]      event_o
);

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    trig_mode_e mode;
    assign mode       = decode_trig(trig_i[p]);
    assign event_o[p] = trig_hit(mode, cur_i[p], prev_i[p]);

    // R8: no trigger bits, or level alone, never fires
    p_quiet_off_r8: assert property (@(posedge clk) disable iff (rst)
      (trig_i[p][2:1] == 2'b00) |-> !event_o[p]);

    // R6: a pure edge mode only fires when the input moved
    p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (rst)
      (!trig_i[p][0] && event_o[p]) |-> (cur_i[p] != prev_i[p]));
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] event_i,
  input  logic [WIDTH-1:0] clear_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= event_i | (status_q & ~clear_i);
  end

  assign status_o = status_q;

  // R10: a cleared bit without a fresh event is gone next cycle
  p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
    (|(clear_i & ~event_i)) |=> ((status_q & $past(clear_i & ~event_i)) == '0));

  // R11: an event always leaves its bit set, even under a clear
  p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (|event_i) |=> ((status_q & $past(event_i)) == $past(event_i)));

  // R10: bits neither written nor triggered keep their value
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ((clear_i | event_i) == '0) |=> $stable(status_q));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PADS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq
);

  localparam int NUM_BANKS  = (NUM_PADS + BANK_BITS - 1) / BANK_BITS;
  localparam int STAT_W     = NUM_BANKS * BANK_BITS;
  localparam int SLOT_SEL_W = ADDR_W - 5;
  localparam int BANK_SEL_W = ADDR_W - 3;

  // ---------------- address decode
  logic                  in_status;
  logic [SLOT_SEL_W-1:0] slot_sel;
  logic [1:0]            slot_word;
  logic [BANK_SEL_W-1:0] bank_sel;
  logic                  wr_strobe;
  logic                  rd_strobe;

  assign in_status = bus_addr[ADDR_W-1];
  assign slot_sel  = bus_addr[ADDR_W-2:4];
  assign slot_word = bus_addr[3:2];
  assign bank_sel  = bus_addr[ADDR_W-2:2];
  assign wr_strobe = bus_en && bus_we;
  assign rd_strobe = bus_en && !bus_we;

  // ---------------- per-pad register storage
  logic [NUM_PADS-1:0][31:0] cfg_q;
  logic [NUM_PADS-1:0][2:0]  val_q;
  logic [NUM_PADS-1:0][2:0]  trig;
  logic [NUM_PADS-1:0]       pin_sync;
  logic [NUM_PADS-1:0]       pin_prev;
  logic [NUM_PADS-1:0]       pad_event;
  logic [NUM_PADS-1:0]       stat_clear;
  logic [NUM_PADS-1:0]       status;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic hit;
    assign hit = wr_strobe && !in_status && (slot_sel == SLOT_SEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[p] <= '0;
        val_q[p] <= VAL_RESET;
      end else if (hit && slot_word == 2'd0) begin
        cfg_q[p] <= cfg_store(bus_wdata);
      end else if (hit && slot_word == 2'd2) begin
        val_q[p] <= bus_wdata[2:0];
      end
    end

    logic od, oe_n, lvl;
    assign od   = cfg_q[p][BIT_OD];
    assign oe_n = val_q[p][1];
    assign lvl  = val_q[p][0];

    assign pad_oe[p]  = !oe_n && (!od || !lvl);
    assign pad_out[p] = od ? 1'b0 : lvl;
    assign trig[p]    = {cfg_q[p][BIT_NEG], cfg_q[p][BIT_POS], cfg_q[p][BIT_LVL]};

    // R4: an open-drain pad never drives high
    p_od_low_only_r4: assert property (@(posedge clk) disable iff (rst)
      (od && pad_oe[p]) |-> !pad_out[p]);

    // R3: a disabled output never drives
    p_oe_gate_r3: assert property (@(posedge clk) disable iff (rst)
      val_q[p][1] |-> !pad_oe[p]);
  end

  // ---------------- input path and event detection
  gpio_in_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in),
    .sync_o  (pin_sync),
    .prev_o  (pin_prev)
  );

  gpio_trig_detect #(.WIDTH(NUM_PADS)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig),
    .cur_i   (pin_sync),
    .prev_i  (pin_prev),
    .event_o (pad_event)
  );

  // ---------------- status write-1-to-clear
  always_comb begin
    for (int i = 0; i < NUM_PADS; i++) begin
      stat_clear[i] = wr_strobe && in_status &&
                      (bank_sel == BANK_SEL_W'(i / BANK_BITS)) &&
                      bus_wdata[i % BANK_BITS];
    end
  end

  gpio_irq_bank #(.WIDTH(NUM_PADS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .event_i  (pad_event),
    .clear_i  (stat_clear),
    .status_o (status)
  );

  assign irq = |status;

  // ---------------- read mux
  logic [STAT_W-1:0] status_wide;
  assign status_wide = STAT_W'(status);

  always_comb begin
    bus_rdata = '0;
    if (rd_strobe) begin
      if (in_status) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bank_sel == BANK_SEL_W'(b))
            bus_rdata = status_wide[b*BANK_BITS +: BANK_BITS];
        end
      end else begin
        for (int p = 0; p < NUM_PADS; p++) begin
          if (slot_sel == SLOT_SEL_W'(p)) begin
            if (slot_word == 2'd0)      bus_rdata = cfg_q[p];
            else if (slot_word == 2'd2) bus_rdata = val_view(val_q[p], pin_sync[p]);
          end
        end
      end
    end
  end

  // R1: the first cycle out of reset shows a clean interrupt state
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((status == '0) && !irq && (pad_oe == '0)));

  // R12: the interrupt line only rises after some pin raised an event
  p_irq_needs_event_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|pad_event));

  // R12: the line stays up while no clear is written
  p_irq_holds_r12: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_strobe && in_status)) |=> irq);

endmodule

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;

  localparam int  N       = 40;
  localparam time CLK_PER = 10ns;
  localparam logic [11:0] STAT0 = 12'h800;
  localparam logic [11:0] STAT1 = 12'h804;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  gpio_pad_ctrl #(.NUM_PADS(N)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [11:0] cfg_addr(int p);  return 12'(p * 16);     endfunction
  function automatic logic [11:0] val_addr(int p);  return 12'(p * 16 + 8); endfunction
  function automatic logic [31:0] bit_of(int i);    return 32'd1 << (i % 32); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read cycle
  always @(negedge clk) begin
    if (bus_en && !bus_we) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic set_pad(int p, logic v);
    @(posedge clk); #1;
    pad_in[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic clear_all();
    bus_write(STAT0, 32'hFFFF_FFFF);
    bus_write(STAT1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pad_oe", 32'(pad_oe), 32'd0);
    bus_read(cfg_addr(0),  32'h0, "R1 cfg pad0");
    bus_read(val_addr(0),  32'h6, "R1 val pad0");
    bus_read(val_addr(39), 32'h6, "R1 val pad39");
    bus_read(STAT0, 32'h0, "R1 status0");
    bus_read(STAT1, 32'h0, "R1 status1");

    // R2 stored bits and slot decode
    bus_write(cfg_addr(5), 32'hF8FF_FFFF);
    bus_read(cfg_addr(5), 32'h8800_0007, "R2 cfg mask pad5");
    bus_write(cfg_addr(39), 32'h0800_0005);
    bus_read(cfg_addr(39), 32'h0800_0005, "R2 cfg pad39");
    bus_read(cfg_addr(38), 32'h0, "R2 neighbour pad38 untouched");
    bus_write(cfg_addr(5), 32'h0);
    bus_write(cfg_addr(39), 32'h0);

    // R3 push-pull output
    bus_write(val_addr(3), 32'h1);
    @(negedge clk);
    check("R3 oe on", {31'd0, pad_oe[3]}, 32'd1);
    check("R3 out high", {31'd0, pad_out[3]}, 32'd1);
    bus_write(val_addr(3), 32'h0);
    @(negedge clk);
    check("R3 out low", {31'd0, pad_out[3]}, 32'd0);
    bus_write(val_addr(3), 32'h3);
    @(negedge clk);
    check("R3 oe off", {31'd0, pad_oe[3]}, 32'd0);

    // R4 open drain
    bus_write(cfg_addr(4), 32'h8000_0000);
    bus_write(val_addr(4), 32'h1);
    @(negedge clk);
    check("R4 od release", {30'd0, pad_oe[4], pad_out[4]}, 32'd0);
    bus_write(val_addr(4), 32'h0);
    @(negedge clk);
    check("R4 od pull low", {30'd0, pad_oe[4], pad_out[4]}, 32'b10);

    // R5 value readback
    bus_write(val_addr(7), 32'h0);
    set_pad(7, 1'b1);
    settle();
    bus_read(val_addr(7), 32'h1, "R5 input sampled high");
    bus_write(val_addr(7), 32'h4);
    bus_read(val_addr(7), 32'h4, "R5 input disabled shows stored level");
    set_pad(7, 1'b0);
    bus_write(val_addr(7), 32'h5);
    settle();
    bus_read(val_addr(7), 32'h5, "R5 stored level high");

    // R6 rising edge with exact latency
    bus_write(cfg_addr(10), 32'h0200_0000);
    set_pad(10, 1'b1);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R6 not yet", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6 rise latency / R12 irq", {31'd0, irq}, 32'd1);
    bus_read(STAT0, bit_of(10), "R6 rise status");
    // R10 writing zeros or other bits leaves it
    bus_write(STAT0, 32'h0);
    bus_write(STAT0, bit_of(11));
    bus_read(STAT0, bit_of(10), "R10 write-0 keeps bit");
    bus_write(STAT0, bit_of(10));
    bus_read(STAT0, 32'h0, "R10 write-1 clears");
    @(negedge clk);
    check("R12 irq low after clear", {31'd0, irq}, 32'd0);
    set_pad(10, 1'b0);
    settle();
    bus_read(STAT0, 32'h0, "R6 rise-only ignores fall");

    // R6 falling edge
    bus_write(cfg_addr(11), 32'h0400_0000);
    set_pad(11, 1'b1);
    settle();
    bus_read(STAT0, 32'h0, "R6 fall-only ignores rise");
    set_pad(11, 1'b0);
    settle();
    bus_read(STAT0, bit_of(11), "R6 fall status");
    clear_all();

    // R6 both edges
    bus_write(cfg_addr(12), 32'h0600_0000);
    set_pad(12, 1'b1);
    settle();
    bus_read(STAT0, bit_of(12), "R6 both rise");
    clear_all();
    set_pad(12, 1'b0);
    settle();
    bus_read(STAT0, bit_of(12), "R6 both fall");
    bus_write(cfg_addr(12), 32'h0);
    clear_all();

    // R9 second bank
    bus_write(cfg_addr(35), 32'h0200_0000);
    set_pad(35, 1'b1);
    settle();
    bus_read(STAT1, bit_of(35), "R9 bank1 bit3");
    bus_read(STAT0, 32'h0, "R9 bank0 unaffected");
    bus_write(STAT1, 32'hFFFF_FFFF);
    bus_read(STAT1, 32'h0, "R9 bank1 cleared, unused bits zero");

    // R7 high level
    bus_write(cfg_addr(20), 32'h0300_0000);
    set_pad(20, 1'b1);
    settle();
    bus_write(STAT0, bit_of(20));
    bus_read(STAT0, bit_of(20), "R7 high level re-sets");
    set_pad(20, 1'b0);
    settle();
    bus_write(STAT0, bit_of(20));
    bus_read(STAT0, 32'h0, "R7 high level released");
    bus_write(cfg_addr(20), 32'h0);

    // R7 low level
    bus_write(cfg_addr(21), 32'h0500_0000);
    settle();
    bus_read(STAT0, bit_of(21), "R7 low level fires");
    set_pad(21, 1'b1);
    settle();
    bus_write(STAT0, bit_of(21));
    bus_read(STAT0, 32'h0, "R7 low level released");
    bus_write(cfg_addr(21), 32'h0);

    // R8 level bit alone and all clear
    bus_write(cfg_addr(15), 32'h0100_0000);
    set_pad(15, 1'b1);
    settle();
    set_pad(15, 1'b0);
    settle();
    set_pad(16, 1'b1);
    settle();
    bus_read(STAT0, 32'h0, "R8 no trigger");
    @(negedge clk);
    check("R8 irq quiet", {31'd0, irq}, 32'd0);

    // R11 clear and event in the same cycle
    bus_write(cfg_addr(13), 32'h0200_0000);
    set_pad(13, 1'b1);
    @(posedge clk);
    bus_write(STAT0, bit_of(13));
    bus_read(STAT0, bit_of(13), "R11 event beats clear");
    clear_all();
    bus_read(STAT0, 32'h0, "R11 later clear works");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule